// File: doc/BRIEF.md
# Tile Video Unit Register Port

This block is the processor-side register window of a tile-based video unit. A CPU reaches eight byte-wide registers through a small address window. Through them it configures the renderer, reads event flags, and moves bytes into two stores. One is the tile/name memory, a 2 KB RAM outside this block. The other is the 256-byte sprite attribute RAM, also outside this block. A 32-entry colour table is held inside the block. The renderer reports frame and sprite events as single-cycle pulses. The block turns these into status flags and into an interrupt request.

Video memory is reached through a 14-bit pointer. The CPU loads the pointer one byte at a time through a single port. A write toggle, shared with the scroll register, records which half comes next. After every read or write of the data port, the pointer moves forward by 1 (along a row) or by 32 (down a column). A control bit selects the step. The pointer's value selects the target: pattern space (read-only here), the 2 KB name memory through a mirroring fold, or the colour table.

Top module: `vid_regport`

## Requirements
- R1: During reset and after it, with no CPU access and no events, all configuration outputs, scroll values, the pointer, the sprite address, the flags, `nmi_req` and the write strobes are zero.
- R2: CPU address 0x2000+n (n = 0..7) selects, in this order: control, mask, status, sprite address, sprite data, scroll, pointer, data. An access at any other address changes nothing and reads as 0x00.
- R3: Control bits [1:0] appear on `cfg_nt_base`, bit 3 on `cfg_spr_table`, bit 4 on `cfg_bg_table`, bit 2 selects the pointer step, and bit 7 enables the interrupt. The mask byte appears on `cfg_mask`. All of them update on the cycle after the write.
- R4: A pointer write with the toggle clear stores bits [5:0] as the upper six pointer bits and leaves the pointer unchanged. A write with the toggle set loads the whole pointer with {stored bits, data byte}. Scroll writes use the same toggle: the first gives X, the second gives Y. Each pointer or scroll write flips the toggle.
- R5: A status read returns {vblank, sprite-0 hit, overflow, 5'b0}. On the following cycle the vblank flag and the toggle are cleared, and the other two flags are kept.
- R6: The event pulses set their flags. A frame-end pulse clears all three flags. A set pulse in the same cycle as a clear (frame end or status read) leaves the flag set.
- R7: `nmi_req` is high exactly while the vblank flag and control bit 7 are both set.
- R8: Each data-port read or write advances the pointer by 1, or by 32 when control bit 2 is set, modulo 2^14.
- R9: Pointer values 0x2000–0x3EFF select the name memory. `nt_addr` = {pointer bit 10, pointer bits [9:0]} with the default mirroring. A data write there pulses `nt_we` with the CPU byte, and a data read returns `nt_rdata`.
- R10: Pointer values 0x3F00–0x3FFF select colour entry = pointer bits [4:0]. Writes store there without `nt_we`, and reads return the stored byte.
- R11: Pointer values below 0x2000 ignore data writes (no strobe) and read as 0x00, but the pointer still steps.
- R12: A sprite-data write pulses `spr_we` at `spr_addr`, and the sprite address then increments modulo 256. A sprite-data read returns `spr_rdata` and leaves the address alone.
- R13: Reads of control, mask, sprite address, scroll and pointer return 0x00 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read byte (same cycle) |
| ev_vblank_start | input | 1 | Vertical-blank start pulse |
| ev_sprite0_hit | input | 1 | Sprite 0 hit pulse |
| ev_sprite_overflow | input | 1 | Sprite overflow pulse |
| ev_frame_end | input | 1 | End of blanking, clears flags |
| nt_addr | output | 11 | Name memory address |
| nt_we | output | 1 | Name memory write strobe |
| nt_wdata | output | 8 | Name memory write byte |
| nt_rdata | input | 8 | Name memory read byte |
| spr_addr | output | 8 | Sprite RAM address |
| spr_we | output | 1 | Sprite RAM write strobe |
| spr_wdata | output | 8 | Sprite RAM write byte |
| spr_rdata | input | 8 | Sprite RAM read byte |
| vram_addr | output | 14 | Current video memory pointer |
| cfg_nt_base | output | 2 | Base name table select |
| cfg_spr_table | output | 1 | Sprite pattern table select |
| cfg_bg_table | output | 1 | Background pattern table select |
| cfg_mask | output | 8 | Mask register |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| nmi_req | output | 1 | Interrupt request |

## Verification
Properties check the following relations on every cycle:
- Each data access moves the pointer by exactly one step.
- A first pointer byte leaves the pointer unchanged.
- A status read without a coinciding set pulse drops vblank.
- A frame end without a set pulse drops the hit flag.
- The interrupt never rises without a vblank pulse or a control write.
- Pattern-space accesses never strobe a store.
- Every sprite write advances the sprite address.

Only the scenarios can show the rest:
- Bytes written through the data port land at the right name-memory and colour slots, and they read back.
- The pointer wraps at 0x3FFF and at the 32-step column boundary.
- The toggle is reset by a status read in the middle of a pointer load.
- Wrong-address accesses are ignored.

// File: rtl/vid_regs_pkg.sv
package vid_regs_pkg;

  typedef enum logic [2:0] {
    REG_CTL  = 3'd0,
    REG_MASK = 3'd1,
    REG_STAT = 3'd2,
    REG_SPTR = 3'd3,
    REG_SDAT = 3'd4,
    REG_SCRL = 3'd5,
    REG_VPTR = 3'd6,
    REG_VDAT = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    RGN_PAT = 2'd0,
    RGN_NT  = 2'd1,
    RGN_PAL = 2'd2
  } vregion_e;

  localparam int CTL_STEP_BIT = 2;
  localparam int CTL_SPR_BIT  = 3;
  localparam int CTL_BG_BIT   = 4;
  localparam int CTL_NMI_BIT  = 7;

  // Pattern space below 0x2000, colour table at 0x3F00 and above,
  // name memory in between.
  function automatic vregion_e classify(input logic [13:0] a);
    if (!a[13])               return RGN_PAT;
    else if (a[13:8] == 6'h3F) return RGN_PAL;
    else                       return RGN_NT;
  endfunction

endpackage

// File: rtl/vid_flag_unit.sv
module vid_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_vbl_set,
  input  logic ev_hit_set,
  input  logic ev_ovf_set,
  input  logic ev_clr_all,
  input  logic stat_rd,
  output logic vbl,
  output logic hit,
  output logic ovf
);

  logic vbl_q, hit_q, ovf_q;
  logic vbl_d, hit_d, ovf_d;
  logic flag_en;

  // clears first, then sets, so a set pulse always wins
  always_comb begin
    vbl_d = vbl_q;
    hit_d = hit_q;
    ovf_d = ovf_q;
    if (ev_clr_all || stat_rd) vbl_d = 1'b0;
    if (ev_clr_all) begin
      hit_d = 1'b0;
      ovf_d = 1'b0;
    end
    if (ev_vbl_set) vbl_d = 1'b1;
    if (ev_hit_set) hit_d = 1'b1;
    if (ev_ovf_set) ovf_d = 1'b1;
  end

  assign flag_en = ev_vbl_set | ev_hit_set | ev_ovf_set | ev_clr_all | stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbl_q <= 1'b0;
      hit_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (flag_en) begin
      vbl_q <= vbl_d;
      hit_q <= hit_d;
      ovf_q <= ovf_d;
    end
  end

  assign vbl = vbl_q;
  assign hit = hit_q;
  assign ovf = ovf_q;

  // R5
  status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ev_vbl_set) |=> !vbl_q);

  // R6
  frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr_all && !ev_hit_set) |=> !hit_q);

endmodule

// File: rtl/vid_addr_unit.sv
module vid_addr_unit #(
  parameter int AW         = 14,
  parameter int STEP_WIDE  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_scroll,
  input  logic          wr_ptr,
  input  logic          data_acc,
  input  logic          step_wide,
  input  logic          toggle_clr,
  input  logic [7:0]    wdata,
  output logic [AW-1:0] vaddr,
  output logic [7:0]    scroll_x,
  output logic [7:0]    scroll_y
);

  localparam int HI_W = AW - 8;

  logic            tog_q, tog_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [AW-1:0]   va_q, va_d, step_v;
  logic [7:0]      sx_q, sx_d, sy_q, sy_d;
  logic            tog_en, hi_en, va_en, sx_en, sy_en;

  assign step_v = step_wide ? AW'(STEP_WIDE) : AW'(1);

  always_comb begin
    tog_d = tog_q;
    if (toggle_clr)             tog_d = 1'b0;
    else if (wr_scroll || wr_ptr) tog_d = ~tog_q;

    hi_d = wdata[HI_W-1:0];
    sx_d = wdata;
    sy_d = wdata;

    if (wr_ptr && tog_q) va_d = {hi_q, wdata};
    else                 va_d = va_q + step_v;
  end

  assign tog_en = toggle_clr | wr_scroll | wr_ptr;
  assign hi_en  = wr_ptr & ~tog_q;
  assign va_en  = (wr_ptr & tog_q) | data_acc;
  assign sx_en  = wr_scroll & ~tog_q;
  assign sy_en  = wr_scroll & tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      hi_q  <= '0;
      va_q  <= '0;
      sx_q  <= '0;
      sy_q  <= '0;
    end else begin
      if (tog_en) tog_q <= tog_d;
      if (hi_en)  hi_q  <= hi_d;
      if (va_en)  va_q  <= va_d;
      if (sx_en)  sx_q  <= sx_d;
      if (sy_en)  sy_q  <= sy_d;
    end
  end

  assign vaddr    = va_q;
  assign scroll_x = sx_q;
  assign scroll_y = sy_q;

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> (va_q == $past(va_q) + $past(step_v)));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr && !tog_q && !data_acc) |=> $stable(va_q));

endmodule

// File: rtl/vid_pal_ram.sv
module vid_pal_ram #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata
);

  logic [7:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (idx == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= 8'h00;
      else if (ent_en) ent_q[g] <= wdata;
    end
  end

  assign rdata = ent_q[idx];

endmodule

// File: rtl/vid_regport.sv
module vid_regport #(
  parameter int          AW           = 14,
  parameter int          NT_BYTES     = 2048,
  parameter int          PAL_DEPTH    = 32,
  parameter int          SPR_AW       = 8,
  parameter int          STEP_WIDE    = 32,
  parameter bit          MIRROR_HORIZ = 1'b0,
  parameter logic [15:0] REG_BASE     = 16'h2000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [15:0]                 cpu_addr,
  input  logic [7:0]                  cpu_wdata,
  input  logic                        cpu_rd,
  input  logic                        cpu_wr,
  output logic [7:0]                  cpu_rdata,
  input  logic                        ev_vblank_start,
  input  logic                        ev_sprite0_hit,
  input  logic                        ev_sprite_overflow,
  input  logic                        ev_frame_end,
  output logic [$clog2(NT_BYTES)-1:0] nt_addr,
  output logic                        nt_we,
  output logic [7:0]                  nt_wdata,
  input  logic [7:0]                  nt_rdata,
  output logic [SPR_AW-1:0]           spr_addr,
  output logic                        spr_we,
  output logic [7:0]                  spr_wdata,
  input  logic [7:0]                  spr_rdata,
  output logic [AW-1:0]               vram_addr,
  output logic [1:0]                  cfg_nt_base,
  output logic                        cfg_spr_table,
  output logic                        cfg_bg_table,
  output logic [7:0]                  cfg_mask,
  output logic [7:0]                  scroll_x,
  output logic [7:0]                  scroll_y,
  output logic                        nmi_req
);
  import vid_regs_pkg::*;

  localparam int NT_AW   = $clog2(NT_BYTES);
  localparam int PAL_IW  = $clog2(PAL_DEPTH);
  localparam int PAGE_B  = MIRROR_HORIZ ? NT_AW : NT_AW - 1;

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i_n = rs2_q;

  // decode
  logic     in_win, wr_hit, rd_hit;
  reg_sel_e sel;
  logic     wr_ctl, wr_mask, wr_sptr, wr_sdat, wr_scrl, wr_vptr;
  logic     stat_rd, data_acc, data_wr;
  logic [AW-1:0] vaddr;
  vregion_e region;
  logic     pal_we;
  logic [7:0] pal_rdata;

  assign in_win   = (cpu_addr[15:3] == REG_BASE[15:3]);
  assign sel      = reg_sel_e'(cpu_addr[2:0]);
  assign wr_hit   = cpu_wr & in_win;
  assign rd_hit   = cpu_rd & in_win;
  assign wr_ctl   = wr_hit & (sel == REG_CTL);
  assign wr_mask  = wr_hit & (sel == REG_MASK);
  assign wr_sptr  = wr_hit & (sel == REG_SPTR);
  assign wr_sdat  = wr_hit & (sel == REG_SDAT);
  assign wr_scrl  = wr_hit & (sel == REG_SCRL);
  assign wr_vptr  = wr_hit & (sel == REG_VPTR);
  assign data_wr  = wr_hit & (sel == REG_VDAT);
  assign data_acc = (wr_hit | rd_hit) & (sel == REG_VDAT);
  assign stat_rd  = rd_hit & (sel == REG_STAT);

  // control, mask and sprite pointer registers
  logic [7:0]        ctl_q, mask_q;
  logic [SPR_AW-1:0] sptr_q, sptr_d;
  logic              sptr_en;

  always_comb begin
    if (wr_sptr) sptr_d = cpu_wdata[SPR_AW-1:0];
    else         sptr_d = sptr_q + 1'b1;
  end
  assign sptr_en = wr_sptr | wr_sdat;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctl_q  <= 8'h00;
      mask_q <= 8'h00;
      sptr_q <= '0;
    end else begin
      if (wr_ctl)  ctl_q  <= cpu_wdata;
      if (wr_mask) mask_q <= cpu_wdata;
      if (sptr_en) sptr_q <= sptr_d;
    end
  end

  // pointer, toggle and scroll
  vid_addr_unit #(.AW(AW), .STEP_WIDE(STEP_WIDE)) u_addr (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_scroll  (wr_scrl),
    .wr_ptr     (wr_vptr),
    .data_acc   (data_acc),
    .step_wide  (ctl_q[CTL_STEP_BIT]),
    .toggle_clr (stat_rd),
    .wdata      (cpu_wdata),
    .vaddr      (vaddr),
    .scroll_x   (scroll_x),
    .scroll_y   (scroll_y)
  );

  // status flags
  logic vbl, hit, ovf;
  vid_flag_unit u_flags (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .ev_vbl_set (ev_vblank_start),
    .ev_hit_set (ev_sprite0_hit),
    .ev_ovf_set (ev_sprite_overflow),
    .ev_clr_all (ev_frame_end),
    .stat_rd    (stat_rd),
    .vbl        (vbl),
    .hit        (hit),
    .ovf        (ovf)
  );

  // video memory routing
  assign region = classify(vaddr);
  assign nt_we  = data_wr & (region == RGN_NT);
  assign pal_we = data_wr & (region == RGN_PAL);
  assign nt_addr  = {vaddr[PAGE_B], vaddr[NT_AW-2:0]};
  assign nt_wdata = cpu_wdata;

  vid_pal_ram #(.DEPTH(PAL_DEPTH)) u_pal (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (pal_we),
    .idx   (vaddr[PAL_IW-1:0]),
    .wdata (cpu_wdata),
    .rdata (pal_rdata)
  );

  // read mux
  always_comb begin
    cpu_rdata = 8'h00;
    if (rd_hit) begin
      case (sel)
        REG_STAT: cpu_rdata = {vbl, hit, ovf, 5'b00000};
        REG_SDAT: cpu_rdata = spr_rdata;
        REG_VDAT: begin
          case (region)
            RGN_NT:  cpu_rdata = nt_rdata;
            RGN_PAL: cpu_rdata = pal_rdata;
            default: cpu_rdata = 8'h00;
          endcase
        end
        default:  cpu_rdata = 8'h00;
      endcase
    end
  end

  assign spr_addr      = sptr_q;
  assign spr_we        = wr_sdat;
  assign spr_wdata     = cpu_wdata;
  assign vram_addr     = vaddr;
  assign cfg_nt_base   = ctl_q[1:0];
  assign cfg_spr_table = ctl_q[CTL_SPR_BIT];
  assign cfg_bg_table  = ctl_q[CTL_BG_BIT];
  assign cfg_mask      = mask_q;
  assign nmi_req       = vbl & ctl_q[CTL_NMI_BIT];

  // R7
  nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(nmi_req) |-> $past(ev_vblank_start || wr_ctl));

  // R11
  pat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (vram_addr < 14'h2000) |-> (!nt_we && !pal_we));

  // R12
  spr_step_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    spr_we |=> (spr_addr == $past(spr_addr) + 1'b1));

endmodule

// File: tb/test_vid_regport.sv
module test_vid_regport;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        ev_vb = 1'b0, ev_h = 1'b0, ev_o = 1'b0, ev_fe = 1'b0;
  logic [10:0] nt_addr;
  logic        nt_we;
  logic [7:0]  nt_wdata, nt_rdata;
  logic [7:0]  spr_addr;
  logic        spr_we;
  logic [7:0]  spr_wdata, spr_rdata;
  logic [13:0] vram_addr;
  logic [1:0]  cfg_nt_base;
  logic        cfg_spr_table, cfg_bg_table;
  logic [7:0]  cfg_mask, scroll_x, scroll_y;
  logic        nmi_req;

  always #5 clk = ~clk;

  vid_regport i_vid_regport (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .ev_vblank_start(ev_vb), .ev_sprite0_hit(ev_h),
    .ev_sprite_overflow(ev_o), .ev_frame_end(ev_fe),
    .nt_addr(nt_addr), .nt_we(nt_we), .nt_wdata(nt_wdata), .nt_rdata(nt_rdata),
    .spr_addr(spr_addr), .spr_we(spr_we), .spr_wdata(spr_wdata),
    .spr_rdata(spr_rdata), .vram_addr(vram_addr), .cfg_nt_base(cfg_nt_base),
    .cfg_spr_table(cfg_spr_table), .cfg_bg_table(cfg_bg_table),
    .cfg_mask(cfg_mask), .scroll_x(scroll_x), .scroll_y(scroll_y),
    .nmi_req(nmi_req)
  );

  // external memories
  logic [7:0] nt_mem [2048];
  logic [7:0] spr_mem [256];
  assign nt_rdata  = nt_mem[nt_addr];
  assign spr_rdata = spr_mem[spr_addr];
  always @(posedge clk) begin
    if (nt_we)  nt_mem[nt_addr]   <= nt_wdata;
    if (spr_we) spr_mem[spr_addr] <= spr_wdata;
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_ctl, m_mask, m_sptr, m_sx, m_sy, m_v, m_hi, m_tog;
  bit m_vbl, m_hit, m_ovf;
  int m_pal [32];

  function automatic int rgn(input int v);   // 0 pattern, 1 names, 2 colours
    if (v < 'h2000) return 0;
    if (v >= 'h3F00) return 2;
    return 1;
  endfunction

  function automatic int fold(input int v);
    return (v % 1024) + (((v / 1024) % 2) * 1024);
  endfunction

  function automatic bit in_win();
    return cpu_addr >= 16'h2000 && cpu_addr <= 16'h2007;
  endfunction

  function automatic int step();
    return ((m_ctl / 4) % 2) ? 32 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 0; m_mask = 0; m_sptr = 0; m_sx = 0; m_sy = 0;
      m_v = 0; m_hi = 0; m_tog = 0; m_vbl = 0; m_hit = 0; m_ovf = 0;
      for (int i = 0; i < 32; i++) m_pal[i] = 0;
    end else begin
      if (cpu_wr && in_win()) begin
        case (cpu_addr - 16'h2000)
          0: m_ctl = cpu_wdata;
          1: m_mask = cpu_wdata;
          3: m_sptr = cpu_wdata;
          4: m_sptr = (m_sptr + 1) % 256;
          5: begin
            if (m_tog == 0) m_sx = cpu_wdata; else m_sy = cpu_wdata;
            m_tog = 1 - m_tog;
          end
          6: begin
            if (m_tog == 0) m_hi = cpu_wdata % 64;
            else m_v = m_hi * 256 + cpu_wdata;
            m_tog = 1 - m_tog;
          end
          7: begin
            if (rgn(m_v) == 2) m_pal[m_v % 32] = cpu_wdata;
            m_v = (m_v + step()) % 16384;
          end
          default: ;
        endcase
      end
      if (cpu_rd && in_win()) begin
        if (cpu_addr == 16'h2002) begin m_vbl = 0; m_tog = 0; end
        if (cpu_addr == 16'h2007) m_v = (m_v + step()) % 16384;
      end
      if (ev_fe) begin m_vbl = 0; m_hit = 0; m_ovf = 0; end
      if (ev_vb) m_vbl = 1;
      if (ev_h)  m_hit = 1;
      if (ev_o)  m_ovf = 1;
    end
  end

  function automatic int exp_rdata();
    if (!(cpu_rd && in_win())) return 0;
    case (cpu_addr - 16'h2000)
      2: return m_vbl * 128 + m_hit * 64 + m_ovf * 32;
      4: return spr_mem[m_sptr];
      7: begin
        if (rgn(m_v) == 1) return nt_mem[fold(m_v)];
        if (rgn(m_v) == 2) return m_pal[m_v % 32];
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    chk("R13 cpu_rdata", cpu_rdata, exp_rdata());
    chk("R9 nt_we", nt_we, (cpu_wr && cpu_addr == 16'h2007 && rgn(m_v) == 1));
    chk("R9 nt_addr", nt_addr, fold(m_v));
    chk("R12 spr_we", spr_we, (cpu_wr && cpu_addr == 16'h2004));
    chk("R12 spr_addr", spr_addr, m_sptr);
    chk("R8 vram_addr", vram_addr, m_v);
    chk("R3 cfg_nt_base", cfg_nt_base, m_ctl % 4);
    chk("R3 cfg_spr_table", cfg_spr_table, (m_ctl / 8) % 2);
    chk("R3 cfg_bg_table", cfg_bg_table, (m_ctl / 16) % 2);
    chk("R3 cfg_mask", cfg_mask, m_mask);
    chk("R4 scroll_x", scroll_x, m_sx);
    chk("R4 scroll_y", scroll_y, m_sy);
    chk("R7 nmi_req", nmi_req, m_vbl && (m_ctl / 128));
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input int exp, input string tag);
    @(posedge clk); #1;
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    chk(tag, cpu_rdata, exp);
    @(posedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  task automatic pulse(input bit vb, input bit h, input bit o, input bit fe);
    @(posedge clk); #1;
    ev_vb = vb; ev_h = h; ev_o = o; ev_fe = fe;
    @(posedge clk); #1;
    ev_vb = 0; ev_h = 0; ev_o = 0; ev_fe = 0;
  endtask

  task automatic set_ptr(input int v);
    wr(16'h2006, 8'((v / 256) % 256));
    wr(16'h2006, 8'(v % 256));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2048; i++) nt_mem[i] = 8'h00;
    for (int i = 0; i < 256; i++)  spr_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset nmi", nmi_req, 0);
    chk("R1 reset ptr", vram_addr, 0);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 idle cfg", {cfg_nt_base, cfg_spr_table, cfg_bg_table}, 0);

    // R3 control and mask fields
    wr(16'h2000, 8'h1B);
    wr(16'h2001, 8'h5A);
    @(negedge clk);
    chk("R3 base", cfg_nt_base, 3);
    chk("R3 spr table", cfg_spr_table, 1);
    chk("R3 bg table", cfg_bg_table, 1);
    chk("R3 mask", cfg_mask, 8'h5A);
    wr(16'h2000, 8'h00);

    // R4 half-loaded pointer holds, R9 name writes
    set_ptr('h3456);
    wr(16'h2006, 8'h20);
    @(negedge clk);
    chk("R4 hold after first byte", vram_addr, 'h3456);
    wr(16'h2006, 8'h05);
    @(negedge clk);
    chk("R4 full load", vram_addr, 'h2005);
    wr(16'h2007, 8'hAA);
    wr(16'h2007, 8'hBB);
    chk("R9 name byte 0x005", nt_mem[11'h005], 8'hAA);
    chk("R9 name byte 0x006", nt_mem[11'h006], 8'hBB);
    chk("R8 step by one", vram_addr, 'h2007);
    set_ptr('h2005);
    rd(16'h2007, 8'hAA, "R9 readback");
    rd(16'h2007, 8'hBB, "R9 readback next");

    // R9 mirroring fold: 0x2400 and 0x2C00 share a page, 0x2800 aliases 0x2000
    set_ptr('h2400); wr(16'h2007, 8'h44);
    set_ptr('h2800); wr(16'h2007, 8'h88);
    chk("R9 page one", nt_mem[11'h400], 8'h44);
    chk("R9 page zero alias", nt_mem[11'h000], 8'h88);
    set_ptr('h3C00);
    rd(16'h2007, 8'h44, "R9 upper mirror");

    // R8 column step and wrap
    wr(16'h2000, 8'h04);
    set_ptr('h2100);
    wr(16'h2007, 8'h01); wr(16'h2007, 8'h02); wr(16'h2007, 8'h03);
    chk("R8 column 0x140", nt_mem[11'h140], 8'h03);
    chk("R8 wide step", vram_addr, 'h2160);
    set_ptr('h3FF0);
    wr(16'h2007, 8'h31);
    @(negedge clk);
    chk("R8 wrap by 32", vram_addr, 'h0010);
    wr(16'h2000, 8'h00);
    set_ptr('h3FFF);
    rd(16'h2007, 8'h00, "R10 empty colour");
    @(negedge clk);
    chk("R8 wrap by one", vram_addr, 'h0000);

    // R10 colour table
    set_ptr('h3F01);
    wr(16'h2007, 8'h11);
    wr(16'h2007, 8'h22);
    set_ptr('h3F21);
    rd(16'h2007, 8'h11, "R10 colour mirror");
    rd(16'h2007, 8'h22, "R10 colour next");

    // R11 pattern space ignored
    set_ptr('h1000);
    wr(16'h2007, 8'h55);
    @(negedge clk);
    chk("R11 step in pattern space", vram_addr, 'h1001);
    set_ptr('h1000);
    rd(16'h2007, 8'h00, "R11 reads zero");

    // R12 sprite RAM
    wr(16'h2003, 8'hFE);
    wr(16'h2004, 8'hC1); wr(16'h2004, 8'hC2); wr(16'h2004, 8'hC3);
    chk("R12 sprite 0xFE", spr_mem[8'hFE], 8'hC1);
    chk("R12 sprite wrap 0x00", spr_mem[8'h00], 8'hC3);
    chk("R12 address after wrap", spr_addr, 1);
    wr(16'h2003, 8'hFF);
    rd(16'h2004, 8'hC2, "R12 sprite read");
    rd(16'h2004, 8'hC2, "R12 read no step");

    // R5 R6 R7 flags and interrupt
    pulse(1, 1, 0, 0);
    @(negedge clk);
    chk("R7 no nmi when disabled", nmi_req, 0);
    wr(16'h2000, 8'h80);
    @(negedge clk);
    chk("R7 nmi on enable", nmi_req, 1);
    rd(16'h2002, 8'hC0, "R5 status value");
    @(negedge clk);
    chk("R7 nmi drops after status read", nmi_req, 0);
    rd(16'h2002, 8'h40, "R5 hit kept");
    // set and status read in the same cycle: set wins
    @(posedge clk); #1;
    cpu_addr = 16'h2002; cpu_rd = 1'b1; ev_vb = 1'b1;
    @(posedge clk); #1;
    cpu_rd = 1'b0; ev_vb = 1'b0;
    @(negedge clk);
    chk("R6 set beats read", nmi_req, 1);
    pulse(0, 0, 1, 0);
    rd(16'h2002, 8'hE0, "R6 all flags");
    pulse(1, 0, 0, 1);
    rd(16'h2002, 8'h80, "R6 frame end vs set");
    pulse(0, 0, 0, 1);
    rd(16'h2002, 8'h00, "R6 frame end clears");

    // R4 R5 toggle reset by status read, shared with scroll
    wr(16'h2006, 8'h21);
    rd(16'h2002, 8'h00, "R5 toggle clear read");
    wr(16'h2006, 8'h22);
    wr(16'h2006, 8'h33);
    @(negedge clk);
    chk("R5 toggle restarted", vram_addr, 'h2233);
    wr(16'h2005, 8'h12);
    wr(16'h2005, 8'h34);
    @(negedge clk);
    chk("R4 scroll x", scroll_x, 8'h12);
    chk("R4 scroll y", scroll_y, 8'h34);

    // R2 R13 out-of-window and write-only reads
    wr(16'h2008, 8'hFF);
    wr(16'h1FFF, 8'hFF);
    wr(16'h4000, 8'hFF);
    rd(16'h2008, 8'h00, "R2 outside window");
    @(negedge clk);
    chk("R2 ctl untouched", cfg_nt_base, 0);
    chk("R2 ptr untouched", vram_addr, 'h2233);
    rd(16'h2000, 8'h00, "R13 control read");
    rd(16'h2006, 8'h00, "R13 pointer read");
    @(negedge clk);
    chk("R13 ptr after read", vram_addr, 'h2233);

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule